// File: doc/BRIEF.md
# Watchdog Interval Timer

This block is an 8-bit up-counter driven by a prescaled copy of the system clock. A control/status register sets the prescale ratio, the operating mode and the run enable. In interval mode each wrap of the counter from 0xFF to 0x00 raises a one-cycle interrupt request and sets a sticky overflow flag. In watchdog mode the same wrap drives a one-cycle pulse on an external overflow output instead, and the flag stays clear.

Software reaches the two registers over a small bus. Writes are guarded by a key in the upper byte of a 16-bit write word, and each register has its own key. Reads return the addressed register at once, on the same cycle. The flag can only be cleared by a handshake: software first reads it as 1, then writes 0 to it.

Three reset sources act on different parts of the block. Power-on reset and hardware standby clear everything. Software standby clears the flag, the mode, the enable, the counter and the prescaler, but it keeps the clock-select field.

Top module: `wdit_timer`

## Requirements
- R1: After power-on reset the control/status register (address 0) reads 0x18 and the counter (address 1) reads 0x00. Both the interrupt request and the overflow output are low.
- R2: The control/status register reads as {flag[7], mode[6], enable[5], 1[4], 1[3], clock-select[2:0]}. Bits 4 and 3 always read 1, whatever value is written to them.
- R3: A write to address 0 takes effect only if bus_wdata[15:8] is 0xA5. A write to address 1 takes effect only if bus_wdata[15:8] is 0x5A. Any other write leaves both registers unchanged.
- R4: While the enable bit is set, the counter advances by one for every D system clocks, where D is 2, 64, 128, 256, 512, 1024, 4096 or 8192 for clock-select values 0 to 7. The first step comes D clocks after the write that set the enable bit.
- R5: While the enable bit is 0, the counter and the prescaler are held at zero, and counter writes have no effect.
- R6: In interval mode (mode = 0) a wrap from 0xFF to 0x00 asserts irq_interval for exactly one cycle. This is the same cycle in which the counter first reads 0x00, and in that cycle the flag reads 1. wdt_ovf stays low.
- R7: In watchdog mode (mode = 1) a wrap asserts wdt_ovf for exactly one cycle, in the cycle in which the counter first reads 0x00. irq_interval stays low and the flag is not set.
- R8: A keyed write to address 0 with bit 7 = 0 clears the flag only if a read of address 0 (bus_rd = 1) returned the flag as 1 beforehand. Writing bit 7 = 1, or writing 0 with no prior read, leaves the flag set. If an overflow and a clear fall in the same cycle, the flag stays set.
- R9: Asserting sw_stby clears the flag, the mode, the enable, the counter and the prescaler, and keeps the clock-select field.
- R10: Asserting hw_stby returns every field, the counter and the prescaler to their power-on values.
- R11: A keyed counter write while the timer is enabled loads the written low byte, which reads back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby: full clear while high |
| sw_stby | input | 1 | Software standby: partial clear while high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; used to arm the flag clear |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Addressed register, combinational |
| irq_interval | output | 1 | Interval-mode overflow request, one cycle |
| wdt_ovf | output | 1 | Watchdog-mode overflow pulse, one cycle |

## Verification
A write or a standby pulse lands on the clock edge that ends its cycle, so its effect is visible on bus_rdata in the next cycle. The counter steps on the edge that completes each group of D prescaler clocks. The overflow pulse and the flag appear together, in the first cycle in which the counter reads 0x00. The reference model in the bench updates on every rising edge from the same inputs, and it compares the outputs and the addressed read data at each falling edge. This lets every one of these latencies be checked in the exact cycle it is due. The directed checks wait a fixed number of edges that is computed from D, or they watch for the pulse and then sample the counter in that same half-cycle.

// File: rtl/wdit_pkg.sv
// Package: shared constants and the register view layout for the
// watchdog interval timer. Assumes an 8-bit register width.
package wdit_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 3;
    localparam int NTAPS = 1 << SEL_W;
    localparam int TAP_FW = 5;

    // Packed view of the control/status register as read by software
    typedef struct packed {
        logic             flag;
        logic             mode;
        logic             en;
        logic [1:0]       rsvd;
        logic [SEL_W-1:0] cks;
    } csr_view_t;

    localparam logic [1:0] RSVD_VALUE = 2'b11;

    typedef enum logic {
        SEL_CSR = 1'b0,
        SEL_CNT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/wdit_bus_decode.sv
// Bus decoder: checks the write key carried in the upper byte and turns
// the raw strobes into per-register write and read pulses.
// Assumes single-cycle strobes sampled on the rising clock edge.
module wdit_bus_decode #(
    parameter int          DATA_W  = 16,
    parameter int          KEY_W   = 8,
    parameter logic [KEY_W-1:0] CSR_KEY = 8'hA5,
    parameter logic [KEY_W-1:0] CNT_KEY = 8'h5A
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              csr_wr,
    output logic              cnt_wr,
    output logic              csr_rd
);
    import wdit_pkg::*;

    logic [KEY_W-1:0] key;
    assign key = bus_wdata[DATA_W-1 -: KEY_W];

    // Keyed write qualification and read decode
    always_comb begin
        csr_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CSR) && (key == CSR_KEY);
        cnt_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CNT) && (key == CNT_KEY);
        csr_rd = bus_rd && (reg_sel_e'(bus_addr) == SEL_CSR);
    end
endmodule

// File: rtl/wdit_prescaler.sv
// Prescaler: free-running divider that is held at zero while clear is
// high. It emits a one-cycle tick when the selected tap completes a period.
// Assumes every tap shift is at least 1 and at most PS_W.
module wdit_prescaler #(
    parameter int PS_W = 13,
    parameter logic [wdit_pkg::NTAPS*wdit_pkg::TAP_FW-1:0] TAP_SHIFTS =
        {5'd13, 5'd12, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6, 5'd1}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic [wdit_pkg::SEL_W-1:0] cks,
    output logic                       tick
);
    import wdit_pkg::*;

    logic [PS_W-1:0]  presc_q;
    logic [NTAPS-1:0] tap_hit;

    // Divider register: counts while running, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   presc_q <= '0;
        else if (clr) presc_q <= '0;
        else          presc_q <= presc_q + 1'b1;
    end

    // One terminal-count detector per tap
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int SH = int'(TAP_SHIFTS[i*TAP_FW +: TAP_FW]);
        assign tap_hit[i] = &presc_q[SH-1:0];
    end

    // Selected tap gated by the run condition
    assign tick = !clr && tap_hit[cks];
endmodule

// File: rtl/wdit_counter.sv
// Counter: 8-bit up-counter with load, a hold-at-zero while disabled, and
// mode-steered one-cycle overflow pulses. Both reset sources clear it.
module wdit_counter #(
    parameter int W = wdit_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stby_clr,
    input  logic         en,
    input  logic         mode,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         irq_pulse,
    output logic         wdt_pulse
);
    // Wrap detection on the step out of all-ones
    assign ovf_evt = en && tick && (&cnt);

    // Count register: load has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n || stby_clr) cnt <= '0;
        else if (!en)           cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (tick)          cnt <= cnt + 1'b1;
    end

    // Overflow pulses steered by the mode bit
    always_ff @(posedge clk) begin
        if (!rst_n || stby_clr) begin
            irq_pulse <= 1'b0;
            wdt_pulse <= 1'b0;
        end else begin
            irq_pulse <= ovf_evt && !mode;
            wdt_pulse <= ovf_evt && mode;
        end
    end
endmodule

// File: rtl/wdit_csr.sv
// Control/status register: mode, enable, clock select and the overflow flag
// with its read-then-write-zero clear. Mode, enable and flag clear in either
// standby; the clock select survives software standby.
module wdit_csr (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hw_stby,
    input  logic                       sw_stby,
    input  logic                       csr_wr,
    input  logic                       csr_rd,
    input  logic [wdit_pkg::REG_W-1:0] wdata,
    input  logic                       flag_set,
    output wdit_pkg::csr_view_t        view
);
    import wdit_pkg::*;

    logic             flag_q, mode_q, en_q, armed_q;
    logic [SEL_W-1:0] cks_q;
    logic             full_clr, part_clr, flag_clr;
    logic             unused_rsvd;

    assign full_clr    = !rst_n || hw_stby;
    assign part_clr    = full_clr || sw_stby;
    assign flag_clr    = csr_wr && !wdata[7] && armed_q && !flag_set;
    assign unused_rsvd = ^wdata[4:3];

    // Mode and enable: cleared by every reset source
    always_ff @(posedge clk) begin
        if (part_clr) begin
            mode_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (csr_wr) begin
            mode_q <= wdata[6];
            en_q   <= wdata[5];
        end
    end

    // Clock select: kept through software standby
    always_ff @(posedge clk) begin
        if (full_clr)    cks_q <= '0;
        else if (csr_wr) cks_q <= wdata[SEL_W-1:0];
    end

    // Overflow flag: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (part_clr)      flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Clear arm: set by reading the flag as 1, dropped when it clears
    always_ff @(posedge clk) begin
        if (part_clr)                armed_q <= 1'b0;
        else if (flag_clr)           armed_q <= 1'b0;
        else if (csr_rd && flag_q)   armed_q <= 1'b1;
    end

    // Software-visible layout
    always_comb begin
        view.flag = flag_q;
        view.mode = mode_q;
        view.en   = en_q;
        view.rsvd = RSVD_VALUE;
        view.cks  = cks_q;
    end
endmodule

// File: rtl/wdit_timer.sv
// Top: watchdog interval timer. Ties the bus decoder, the control/status
// register, the prescaler and the counter together and muxes read data.
// Assumes a synchronous active-low power-on reset and level standby inputs.
module wdit_timer #(
    parameter int          DATA_W  = 16,
    parameter int          PS_W    = 13,
    parameter logic [7:0]  CSR_KEY = 8'hA5,
    parameter logic [7:0]  CNT_KEY = 8'h5A,
    parameter logic [wdit_pkg::NTAPS*wdit_pkg::TAP_FW-1:0] TAP_SHIFTS =
        {5'd13, 5'd12, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6, 5'd1}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hw_stby,
    input  logic                       sw_stby,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic                       bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [wdit_pkg::REG_W-1:0] bus_rdata,
    output logic                       irq_interval,
    output logic                       wdt_ovf
);
    import wdit_pkg::*;

    localparam int KEY_W = DATA_W - REG_W;

    logic             csr_wr, cnt_wr, csr_rd;
    csr_view_t        csr_q;
    logic             csr_flag, csr_en;
    logic             tick, ovf_evt, stby_any;
    logic [REG_W-1:0] cnt_q;

    assign csr_flag = csr_q.flag;
    assign csr_en   = csr_q.en;
    assign stby_any = hw_stby || sw_stby;

    wdit_bus_decode #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .CSR_KEY(CSR_KEY),
        .CNT_KEY(CNT_KEY)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .csr_wr   (csr_wr),
        .cnt_wr   (cnt_wr),
        .csr_rd   (csr_rd)
    );

    wdit_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .csr_wr  (csr_wr),
        .csr_rd  (csr_rd),
        .wdata   (bus_wdata[REG_W-1:0]),
        .flag_set(ovf_evt && !csr_q.mode),
        .view    (csr_q)
    );

    wdit_prescaler #(
        .PS_W      (PS_W),
        .TAP_SHIFTS(TAP_SHIFTS)
    ) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!csr_q.en || stby_any),
        .cks  (csr_q.cks),
        .tick (tick)
    );

    wdit_counter #(
        .W(REG_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .stby_clr (stby_any),
        .en       (csr_q.en),
        .mode     (csr_q.mode),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (bus_wdata[REG_W-1:0]),
        .cnt      (cnt_q),
        .ovf_evt  (ovf_evt),
        .irq_pulse(irq_interval),
        .wdt_pulse(wdt_ovf)
    );

    // Read data: addressed register, no wait state
    always_comb begin
        if (reg_sel_e'(bus_addr) == SEL_CNT) bus_rdata = cnt_q;
        else                                 bus_rdata = csr_q;
    end
endmodule

// File: rtl/wdit_timer_chk.sv
// Checker: temporal properties of the watchdog interval timer, bound to
// the top module.
module wdit_timer_chk #(
    parameter int         DATA_W  = 16,
    parameter logic [7:0] CSR_KEY = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_interval,
    input logic              wdt_ovf,
    input logic              csr_flag,
    input logic              csr_en,
    input logic [7:0]        cnt_q
);
    // R6: the interval request lasts a single cycle
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_interval |=> !irq_interval);

    // R7: the watchdog pulse lasts a single cycle
    a_r7_wdt_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> !wdt_ovf);

    // R7: the two overflow actions never coincide
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_interval && wdt_ovf));

    // R6: the flag only rises together with an interval request
    a_r6_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_flag) |-> irq_interval);

    // R5: a timer disabled for two cycles shows a zero count
    a_r5_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_en && $past(!csr_en)) |-> (cnt_q == 8'h00));

    // R8: the flag falls only after a keyed zero write or a reset source
    a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_flag) |-> $past(!rst_n || hw_stby || sw_stby ||
            (bus_wr && !bus_addr && bus_wdata[DATA_W-1 -: 8] == CSR_KEY
             && !bus_wdata[7])));
endmodule

bind wdit_timer wdit_timer_chk #(
    .DATA_W (DATA_W),
    .CSR_KEY(CSR_KEY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_stby     (hw_stby),
    .sw_stby     (sw_stby),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq_interval(irq_interval),
    .wdt_ovf     (wdt_ovf),
    .csr_flag    (csr_flag),
    .csr_en      (csr_en),
    .cnt_q       (cnt_q)
);

// File: tb/sim_wdit_timer.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks per requirement.
module sim_wdit_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [7:0]  bus_rdata;
    logic        irq_interval;
    logic        wdt_ovf;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Reference model state
    int m_presc = 0, m_cnt = 0, m_cks = 0;
    bit m_flag = 0, m_mode = 0, m_en = 0, m_armed = 0, m_irq = 0, m_wdt = 0;

    wdit_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_stby     (hw_stby),
        .sw_stby     (sw_stby),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_interval(irq_interval),
        .wdt_ovf     (wdt_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int divisor(input int sel);
        case (sel)
            0: return 2;
            1: return 64;
            2: return 128;
            3: return 256;
            4: return 512;
            5: return 1024;
            6: return 4096;
            default: return 8192;
        endcase
    endfunction

    function automatic int model_view(input bit addr);
        if (addr) return m_cnt;
        return (m_flag ? 128 : 0) + (m_mode ? 64 : 0) + (m_en ? 32 : 0) + 24 + m_cks;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model update on each rising edge
    always @(posedge clk) begin
        bit tick, ovf, cwr, nwr, clr;
        started = 1'b1;
        if (!rst_n || hw_stby) begin
            m_presc = 0; m_cnt = 0; m_cks = 0; m_flag = 0; m_mode = 0;
            m_en = 0; m_armed = 0; m_irq = 0; m_wdt = 0;
        end else if (sw_stby) begin
            m_presc = 0; m_cnt = 0; m_flag = 0; m_mode = 0;
            m_en = 0; m_armed = 0; m_irq = 0; m_wdt = 0;
        end else begin
            tick = m_en && ((m_presc % divisor(m_cks)) == divisor(m_cks) - 1);
            ovf  = tick && (m_cnt == 255);
            cwr  = bus_wr && !bus_addr && (bus_wdata[15:8] == 8'hA5);
            nwr  = bus_wr && bus_addr && (bus_wdata[15:8] == 8'h5A);
            clr  = cwr && !bus_wdata[7] && m_armed && !(ovf && !m_mode);
            m_irq = ovf && !m_mode;
            m_wdt = ovf && m_mode;
            if (bus_rd && !bus_addr && m_flag && !clr) m_armed = 1;
            if (clr) begin m_flag = 0; m_armed = 0; end
            if (ovf && !m_mode) m_flag = 1;
            if (!m_en) m_cnt = 0;
            else if (nwr) m_cnt = bus_wdata[7:0];
            else if (tick) m_cnt = (m_cnt + 1) % 256;
            m_presc = m_en ? (m_presc + 1) % 8192 : 0;
            if (cwr) begin
                m_mode = bus_wdata[6]; m_en = bus_wdata[5]; m_cks = bus_wdata[2:0];
            end
        end
    end

    // Per-cycle comparison against the model away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R6 model irq", irq_interval, m_irq);
            check("R7 model wdt", wdt_ovf, m_wdt);
            check("R4 model rdata", bus_rdata, model_view(bus_addr));
        end
    end

    task automatic wr(input bit addr, input logic [15:0] data);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(input bit addr, output int val);
        #1;
        bus_addr = addr; bus_rd = 1'b0;
        @(negedge clk);
        val = bus_rdata;
    endtask

    task automatic rd_csr();
        @(posedge clk); #1;
        bus_addr = 1'b0; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_pulse(input bit want_wdt, output bit seen);
        seen = 1'b0;
        bus_addr = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if ((want_wdt ? wdt_ovf : irq_interval) === 1'b1) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Watchdog: an expired run is a failure and still reports
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        bit seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: power-on values
        peek(1'b0, v); check("R1 csr reset", v, 8'h18);
        peek(1'b1, v); check("R1 count reset", v, 8'h00);
        check("R1 irq low", irq_interval, 0);
        check("R1 wdt low", wdt_ovf, 0);

        // R2: reserved bits read 1 regardless of writes
        wr(1'b0, 16'hA5FF); peek(1'b0, v); check("R2 all ones write", v, 8'h7F);
        wr(1'b0, 16'hA500); peek(1'b0, v); check("R2 zero write", v, 8'h18);

        // R3: wrong or swapped keys are ignored
        wr(1'b0, 16'h0027); peek(1'b0, v); check("R3 no key csr", v, 8'h18);
        wr(1'b0, 16'h5A27); peek(1'b0, v); check("R3 counter key on csr", v, 8'h18);
        wr(1'b0, 16'hA527);
        wr(1'b1, 16'hA544); peek(1'b1, v); check("R3 csr key on count", v, 8'h00);

        // R11: keyed counter load while running
        wr(1'b1, 16'h5A44); peek(1'b1, v); check("R11 load", v, 8'h44);

        // R5: counter writes ignored while disabled
        wr(1'b0, 16'hA500);
        wr(1'b1, 16'h5A33); peek(1'b1, v); check("R5 disabled load", v, 8'h00);

        // R4: step rate for three taps
        wr(1'b0, 16'hA520);
        repeat (11) @(posedge clk);
        peek(1'b1, v); check("R4 div2", v, 5);
        wr(1'b0, 16'hA500);
        wr(1'b0, 16'hA521);
        repeat (130) @(posedge clk);
        peek(1'b1, v); check("R4 div64", v, 2);
        wr(1'b0, 16'hA500);
        wr(1'b0, 16'hA527);
        repeat (8200) @(posedge clk);
        peek(1'b1, v); check("R4 div8192", v, 1);

        // R6: interval-mode overflow
        wr(1'b0, 16'hA520);
        wr(1'b1, 16'h5AF0);
        wait_pulse(1'b0, seen);
        check("R6 irq seen", seen, 1);
        check("R6 count zero at irq", bus_rdata, 8'h00);
        check("R6 wdt stays low", wdt_ovf, 0);
        @(negedge clk); check("R6 irq one cycle", irq_interval, 0);
        peek(1'b0, v); check("R6 flag set", v, 8'hB8);

        // R8: clear handshake
        wr(1'b0, 16'hA520); peek(1'b0, v); check("R8 no prior read", v, 8'hB8);
        wr(1'b0, 16'hA5A0); peek(1'b0, v); check("R8 write one", v, 8'hB8);
        rd_csr();
        wr(1'b0, 16'hA520); peek(1'b0, v); check("R8 read then zero", v, 8'h38);

        // R7: watchdog-mode overflow
        wr(1'b0, 16'hA560);
        wr(1'b1, 16'h5AF0);
        wait_pulse(1'b1, seen);
        check("R7 wdt seen", seen, 1);
        check("R7 count zero at wdt", bus_rdata, 8'h00);
        check("R7 irq stays low", irq_interval, 0);
        @(negedge clk); check("R7 wdt one cycle", wdt_ovf, 0);
        peek(1'b0, v); check("R7 flag clear", v, 8'h78);

        // R9: software standby keeps clock select
        wr(1'b0, 16'hA525);
        wr(1'b1, 16'h5A10);
        @(posedge clk); #1 sw_stby = 1'b1;
        @(posedge clk); #1 sw_stby = 1'b0;
        peek(1'b0, v); check("R9 csr after sw standby", v, 8'h1D);
        peek(1'b1, v); check("R9 count after sw standby", v, 8'h00);

        // R10: hardware standby clears everything
        wr(1'b0, 16'hA527);
        wr(1'b1, 16'h5A10);
        @(posedge clk); #1 hw_stby = 1'b1;
        @(posedge clk); #1 hw_stby = 1'b0;
        peek(1'b0, v); check("R10 csr after hw standby", v, 8'h18);
        peek(1'b1, v); check("R10 count after hw standby", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule